// File: doc/BRIEF.md
# Banked Scratchpad Row-Stride Search Engine

This block picks a row stride for an on-chip scratchpad that is interleaved across banks at a fixed byte granule. A client supplies a base stride in bytes, a candidate count and a start pulse. The engine then tries one candidate stride per clock: the base granule count, then base plus one, and so on. It maps each candidate to a bank, looks up that bank's conflict cost in a local table and keeps the cheapest candidate. When the search ends it pulses `done` and presents the winning stride in bytes together with its cost.

The per-bank cost table lives inside the block and is loaded through a one-entry-per-cycle write port. Writes may arrive at any time, including while a search is running. The search never proposes a stride above a fixed ceiling. A base stride that is already past the ceiling ends the request at once with an error flag.

Top module: `scs_stride_search`

## Requirements
- R1: After reset `busy`, `done` and `err` are 0, `chosen_stride` is 0 and `chosen_cost` is all ones.
- R2: An accepted start sets the first candidate to floor(`base_stride`/16) granules and the later candidates to that value plus k, for k = 0 .. L-1, one per clock. L is `span`, except that 0 counts as 1 and values above 64 count as 64. `done` is high in the (1+N)th cycle after the start edge, where N is the number of candidates evaluated.
- R3: A candidate's bank is its granule count modulo 64, and its cost is the table entry at that bank. Bank numbering wraps from 63 to 0.
- R4: The first candidate is always taken. A later candidate replaces the held best only if its cost is strictly lower, so on a tie the earlier candidate is kept.
- R5: No candidate exceeds 131072 granules (2 MB). The search stops after evaluating candidate 131072 even if fewer than L candidates were tried.
- R6: `chosen_stride` equals the winning granule count times 16, and `chosen_cost` equals the winner's table cost.
- R7: `done` is a single-cycle pulse. `busy` is high while candidates are being evaluated and low in the `done` cycle.
- R8: A start pulse while `busy` is high has no effect: no second result, and the running search is unchanged.
- R9: If floor(`base_stride`/16) exceeds 131072, `done` pulses in the cycle after the start edge with `err` = 1, `chosen_stride` = 0 and `chosen_cost` all ones. The next accepted start clears `err`.
- R10: A table write takes effect at its clock edge. A candidate evaluated in the same cycle as a write to its bank uses the old entry, and candidates evaluated in later cycles use the new one.
- R11: The result outputs hold their values after `done` until the next search completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cost_we | input | 1 | Cost table write enable |
| cost_addr | input | 6 | Bank whose cost entry is written |
| cost_data | input | 16 | Unsigned cost value to write |
| start | input | 1 | Request pulse, sampled while idle |
| base_stride | input | 32 | Requested base stride in bytes |
| span | input | 7 | Number of candidates to try (0 means 1, capped at 64) |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Base stride above the ceiling |
| chosen_stride | output | 32 | Winning stride in bytes |
| chosen_cost | output | 16 | Cost of the winning stride |

## Verification
A table write and the scan's lookup can hit the same bank in the same clock. The bench provokes this by counting clocks from the start edge and raising the write enable in exactly the cycle in which candidate k reads its bank. That entry holds a low cost before the write and a high cost after it, so the result shows which value the scan used: the candidate must still win with the old cost. A second run places a write a few cycles ahead of the candidate that reads it, and there the new value must decide the winner.

// File: rtl/scs_pkg.sv
package scs_pkg;
   typedef enum logic [0:0] {
      ST_IDLE = 1'b0,
      ST_SCAN = 1'b1
   } scs_state_e;
endpackage

// File: rtl/scs_cost_table.sv
module scs_cost_table #(
   parameter int NB = 64,
   parameter int CW = 16,
   localparam int AW = $clog2(NB)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [CW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [CW-1:0] rdata
);
   logic [CW-1:0] ent [NB];

   for (genvar i = 0; i < NB; i++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            ent[i] <= '0;
         else if (we && (waddr == AW'(i)))
            ent[i] <= wdata;
      end
   end

   // Combinational read: a write landing at this edge is seen next cycle.
   assign rdata = ent[raddr];
endmodule

// File: rtl/scs_cand_gen.sv
module scs_cand_gen #(
   parameter int GW = 28,
   parameter int MAX_STEPS = 64,
   parameter logic [GW-1:0] MAX_G = '1,
   localparam int KW = $clog2(MAX_STEPS + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          step,
   input  logic [GW-1:0] base_gran,
   input  logic [KW-1:0] lim_raw,
   output logic [GW-1:0] cand,
   output logic [KW-1:0] kidx,
   output logic [KW-1:0] lim_eff,
   output logic          last
);
   logic [KW-1:0] lim_clamp;

   always_comb begin
      if (lim_raw == '0)
         lim_clamp = KW'(1);
      else if (lim_raw > KW'(MAX_STEPS))
         lim_clamp = KW'(MAX_STEPS);
      else
         lim_clamp = lim_raw;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cand    <= '0;
         kidx    <= '0;
         lim_eff <= KW'(1);
      end else if (load) begin
         cand    <= base_gran;
         kidx    <= '0;
         lim_eff <= lim_clamp;
      end else if (step) begin
         cand    <= cand + GW'(1);
         kidx    <= kidx + KW'(1);
      end
   end

   // Stop on the count limit or once the ceiling candidate has been tried.
   assign last = (kidx == lim_eff - KW'(1)) || (cand >= MAX_G);
endmodule

// File: rtl/scs_best_keep.sv
module scs_best_keep #(
   parameter int GW = 28,
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          eval,
   input  logic          first,
   input  logic [CW-1:0] cost_in,
   input  logic [GW-1:0] cand_in,
   output logic [CW-1:0] best_cost,
   output logic [CW-1:0] nxt_cost,
   output logic [GW-1:0] nxt_gran
);
   logic [GW-1:0] best_gran;
   logic          take;

   assign take     = first || (cost_in < best_cost);
   assign nxt_cost = take ? cost_in : best_cost;
   assign nxt_gran = take ? cand_in : best_gran;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         best_cost <= '1;
         best_gran <= '0;
      end else if (clear) begin
         best_cost <= '1;
         best_gran <= '0;
      end else if (eval) begin
         best_cost <= nxt_cost;
         best_gran <= nxt_gran;
      end
   end
endmodule

// File: rtl/scs_stride_search.sv
module scs_stride_search
   import scs_pkg::*;
#(
   parameter int STRIDE_W         = 32,
   parameter int GRAN_BYTES       = 16,
   parameter int NUM_BANKS        = 64,
   parameter int COST_W           = 16,
   parameter int MAX_STRIDE_BYTES = 2097152,
   parameter int MAX_STEPS        = 64,
   localparam int GSH = $clog2(GRAN_BYTES),
   localparam int GW  = STRIDE_W - GSH,
   localparam int AW  = $clog2(NUM_BANKS),
   localparam int KW  = $clog2(MAX_STEPS + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cost_we,
   input  logic [AW-1:0]       cost_addr,
   input  logic [COST_W-1:0]   cost_data,
   input  logic                start,
   input  logic [STRIDE_W-1:0] base_stride,
   input  logic [KW-1:0]       span,
   output logic                busy,
   output logic                done,
   output logic                err,
   output logic [STRIDE_W-1:0] chosen_stride,
   output logic [COST_W-1:0]   chosen_cost
);
   localparam logic [GW-1:0] MAX_G = GW'(MAX_STRIDE_BYTES / GRAN_BYTES);

   if ((1 << GSH) != GRAN_BYTES) begin : g_bad_gran
      $error("GRAN_BYTES must be a power of two");
   end
   if (NUM_BANKS < 2) begin : g_bad_banks
      $error("NUM_BANKS must be at least 2");
   end
   if (MAX_STEPS < 1) begin : g_bad_steps
      $error("MAX_STEPS must be at least 1");
   end
   if (MAX_STRIDE_BYTES % GRAN_BYTES != 0) begin : g_bad_ceil
      $error("MAX_STRIDE_BYTES must be a multiple of GRAN_BYTES");
   end

   scs_state_e    state_q;
   logic [GW-1:0] base_gran, cand_w, nxt_gran;
   logic [KW-1:0] kidx_w, lim_w;
   logic [AW-1:0] bank_w;
   logic [COST_W-1:0] cost_w, best_cost_w, nxt_cost;
   logic          accept, over, load, scan, last_w, fin;

   assign base_gran = base_stride[STRIDE_W-1:GSH];
   assign scan      = (state_q == ST_SCAN);
   assign accept    = start && (state_q == ST_IDLE);
   assign over      = base_gran > MAX_G;
   assign load      = accept && !over;
   assign fin       = scan && last_w;
   assign busy      = scan;

   if ((1 << AW) == NUM_BANKS) begin : g_bank_pow2
      assign bank_w = cand_w[AW-1:0];
   end else begin : g_bank_mod
      assign bank_w = AW'(cand_w % GW'(NUM_BANKS));
   end

   scs_cost_table #(.NB(NUM_BANKS), .CW(COST_W)) u_tbl (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cost_we),
      .waddr (cost_addr),
      .wdata (cost_data),
      .raddr (bank_w),
      .rdata (cost_w)
   );

   scs_cand_gen #(.GW(GW), .MAX_STEPS(MAX_STEPS), .MAX_G(MAX_G)) u_gen (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .step      (scan && !last_w),
      .base_gran (base_gran),
      .lim_raw   (span),
      .cand      (cand_w),
      .kidx      (kidx_w),
      .lim_eff   (lim_w),
      .last      (last_w)
   );

   scs_best_keep #(.GW(GW), .CW(COST_W)) u_best (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (load),
      .eval      (scan),
      .first     (kidx_w == '0),
      .cost_in   (cost_w),
      .cand_in   (cand_w),
      .best_cost (best_cost_w),
      .nxt_cost  (nxt_cost),
      .nxt_gran  (nxt_gran)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q       <= ST_IDLE;
         done          <= 1'b0;
         err           <= 1'b0;
         chosen_stride <= '0;
         chosen_cost   <= '1;
      end else begin
         done <= 1'b0;
         if (accept) begin
            if (over) begin
               done          <= 1'b1;
               err           <= 1'b1;
               chosen_stride <= '0;
               chosen_cost   <= '1;
            end else begin
               state_q <= ST_SCAN;
               err     <= 1'b0;
            end
         end
         if (fin) begin
            state_q       <= ST_IDLE;
            done          <= 1'b1;
            chosen_stride <= {nxt_gran, GSH'(0)};
            chosen_cost   <= nxt_cost;
         end
      end
   end
endmodule

// File: rtl/scs_stride_search_chk.sv
module scs_stride_search_chk #(
   parameter int GW = 28,
   parameter int CW = 16,
   parameter int KW = 7,
   parameter logic [GW-1:0] MAX_G = '1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic          busy,
   input logic          done,
   input logic          err,
   input logic [GW-1:0] cand,
   input logic [KW-1:0] lim_eff,
   input logic [CW-1:0] best_cost
);
   a_r2_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (!busy || cand == $past(cand) + GW'(1)))
      else $error("candidate did not advance by one granule");

   a_r4_best_nonincreasing: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (best_cost <= $past(best_cost)))
      else $error("held best cost rose during a scan");

   a_r5_under_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (cand <= MAX_G))
      else $error("candidate above the ceiling");

   a_r7_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> !done)
      else $error("done longer than one cycle");

   a_r7_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy)
      else $error("busy high with done");

   a_r8_limit_kept: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (!busy || $stable(lim_eff)))
      else $error("candidate limit changed mid-scan");

   a_r9_err_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> !busy)
      else $error("error flag set while scanning");
endmodule

bind scs_stride_search scs_stride_search_chk #(
   .GW(GW), .CW(COST_W), .KW(KW), .MAX_G(MAX_G)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .busy      (busy),
   .done      (done),
   .err       (err),
   .cand      (cand_w),
   .lim_eff   (lim_w),
   .best_cost (best_cost_w)
);

// File: tb/sim_scs_stride_search.sv
`timescale 1ns/1ps
module sim_scs_stride_search;
   localparam int MAXG = 131072;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cost_we = 1'b0;
   logic [5:0]  cost_addr = '0;
   logic [15:0] cost_data = '0;
   logic        start = 1'b0;
   logic [31:0] base_stride = '0;
   logic [6:0]  span = '0;
   logic        busy, done, err;
   logic [31:0] chosen_stride;
   logic [15:0] chosen_cost;

   scs_stride_search u0 (
      .clk(clk), .rst_n(rst_n), .cost_we(cost_we), .cost_addr(cost_addr),
      .cost_data(cost_data), .start(start), .base_stride(base_stride),
      .span(span), .busy(busy), .done(done), .err(err),
      .chosen_stride(chosen_stride), .chosen_cost(chosen_cost)
   );

   always #4 clk = ~clk;

   typedef struct {
      logic [31:0] stride;
      logic [15:0] cost;
      bit          e;
      int          when;
   } exp_t;

   exp_t        q[$];
   logic [15:0] tbl_m [64];
   int          cyc = 0;
   int          total = 0;
   int          bad = 0;
   int          dones = 0;
   int          launches = 0;
   bit          fin_flag = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic void model(input logic [31:0] base, input int lim,
                                 output exp_t x, output int n);
      int g, l, c;
      logic [15:0] best;
      int bg;
      g = int'(base >> 4);
      n = 0;
      x.e = 0;
      if (g > MAXG) begin
         x.e = 1; x.stride = '0; x.cost = '1;
         return;
      end
      l = (lim == 0) ? 1 : ((lim > 64) ? 64 : lim);
      best = '1; bg = 0;
      for (int k = 0; k < l; k++) begin
         c = g + k;
         if (c > MAXG) break;
         if (k == 0 || tbl_m[c % 64] < best) begin
            best = tbl_m[c % 64];
            bg = c;
         end
         n++;
      end
      x.stride = 32'(bg) << 4;
      x.cost = best;
   endfunction

   task automatic wr_hw(input int a, input logic [15:0] d);
      @(negedge clk);
      cost_we = 1'b1; cost_addr = 6'(a); cost_data = d;
      @(negedge clk);
      cost_we = 1'b0;
   endtask

   task automatic fill(input int mul, input int add);
      for (int i = 0; i < 64; i++) begin
         tbl_m[i] = 16'((i * mul + add) % 4001 + 100);
         wr_hw(i, tbl_m[i]);
      end
   endtask

   // Driver: returns at the negedge just after the start edge.
   task automatic launch(input logic [31:0] base, input int lim);
      exp_t x;
      int n;
      model(base, lim, x, n);
      @(negedge clk);
      base_stride = base; span = 7'(lim); start = 1'b1;
      x.when = cyc + 1 + n;
      q.push_back(x);
      launches++;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic drain();
      while (q.size() != 0) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   // Monitor: compare each done against the oldest expected item.
   initial begin
      bit prev = 0;
      exp_t x;
      forever begin
         @(negedge clk);
         if (rst_n && done) begin
            dones++;
            chk(!prev, "R7 done pulse width", prev, 0);
            chk(!busy, "R7 busy low at done", busy, 0);
            if (q.size() == 0) begin
               chk(0, "R8 unexpected result", 1, 0);
            end else begin
               x = q.pop_front();
               chk(chosen_stride == x.stride, "R6 stride", chosen_stride, x.stride);
               chk(chosen_stride[3:0] == 4'h0, "R6 alignment", chosen_stride[3:0], 0);
               chk(chosen_cost == x.cost, "R3/R4 cost", chosen_cost, x.cost);
               chk(err == x.e, "R9 error flag", err, x.e);
               chk(cyc == x.when, "R2 latency", cyc, x.when);
            end
         end
         prev = rst_n && done;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!fin_flag) begin
         total++; bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int k;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(busy == 0 && done == 0 && err == 0, "R1 flags", {busy, done, err}, 0);
      chk(chosen_stride == 0, "R1 stride", chosen_stride, 0);
      chk(chosen_cost == 16'hFFFF, "R1 cost", chosen_cost, 16'hFFFF);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R3 full scan over every bank
      fill(37, 11);
      launch(32'h1000, 64); drain();
      launch(32'h0000_3450, 40); drain();
      // R3 bank wrap 63 -> 0
      launch(32'(60 * 16), 10); drain();

      // R4 ties keep the earlier candidate
      tbl_m[14] = 16'd5; wr_hw(14, 16'd5);
      tbl_m[20] = 16'd5; wr_hw(20, 16'd5);
      launch(32'((64 * 3 + 10) * 16), 16); drain();
      chk(chosen_stride == 32'((64 * 3 + 14) * 16), "R4 tie earliest", chosen_stride, (64 * 3 + 14) * 16);

      // R4 first candidate taken even at all-ones cost
      for (int i = 0; i < 64; i++) begin tbl_m[i] = 16'hFFFF; wr_hw(i, 16'hFFFF); end
      launch(32'(500 * 16), 8); drain();
      chk(chosen_stride == 32'(500 * 16), "R4 first accepted", chosen_stride, 500 * 16);

      // R2 span edges and an unaligned base
      fill(53, 7);
      launch(32'h0000_1237, 0); drain();
      launch(32'h0000_2000, 100); drain();
      launch(32'h0000_2008, 1); drain();

      // R5 ceiling cut and exact ceiling
      launch(32'((MAXG - 3) * 16), 10); drain();
      launch(32'(MAXG * 16), 5); drain();
      // R9 over ceiling, then clearing
      launch(32'((MAXG + 1) * 16), 5); drain();
      chk(err == 1, "R9 err held", err, 1);
      launch(32'h0000_4000, 4); drain();
      chk(err == 0, "R9 err cleared", err, 0);

      // R8 start while busy is ignored; R7 busy during scan
      launch(32'h0000_8000, 20);
      repeat (4) @(negedge clk);
      chk(busy == 1, "R7 busy mid-scan", busy, 1);
      base_stride = 32'h0000_0010; span = 7'd1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      drain();
      repeat (4) @(negedge clk);
      chk(dones == launches, "R8 result count", dones, launches);

      // R10 same-cycle write: candidate k reads old value
      for (int i = 0; i < 64; i++) begin tbl_m[i] = 16'd1000; wr_hw(i, 16'd1000); end
      tbl_m[3] = 16'd10; wr_hw(3, 16'd10);
      k = 3;
      launch(32'(128 * 16), 8);
      repeat (k) @(negedge clk);
      cost_we = 1'b1; cost_addr = 6'd3; cost_data = 16'd2000;
      @(negedge clk);
      cost_we = 1'b0;
      drain();
      chk(chosen_cost == 16'd10, "R10 same-cycle old value", chosen_cost, 10);
      tbl_m[3] = 16'd2000;

      // R10 earlier write: later candidate sees new value
      tbl_m[6] = 16'd7;
      launch(32'(128 * 16), 8);
      cost_we = 1'b1; cost_addr = 6'd6; cost_data = 16'd7;
      @(negedge clk);
      cost_we = 1'b0;
      drain();
      chk(chosen_stride == 32'(134 * 16), "R10 new value", chosen_stride, 134 * 16);

      // R11 results hold
      repeat (6) @(negedge clk);
      chk(chosen_stride == 32'(134 * 16), "R11 stride held", chosen_stride, 134 * 16);
      chk(chosen_cost == 16'd7, "R11 cost held", chosen_cost, 7);

      fin_flag = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule